// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

The block is a watchdog peripheral that sits on a simple 32-bit write/read register bus. A 32 kHz tick enable drives it. Software sets a timeout length in units of 512 ticks, enables the countdown, and must write a restart word before the time runs out. If it does not, the block drives a system reset for a fixed number of ticks. Each register accepts a write only when the write carries that register's own key. A write with a wrong key changes nothing.

In two-stage mode, the first expiry of the programmed length raises an interrupt that warns software. If the restart word is still not written, a second expiry of the same length asserts the system reset. A separate keyed register asserts the system reset at once, whether or not the watchdog is enabled. The reset is also sent to an external pin. That pin can be switched on or off, and its polarity can be chosen. When the reset pulse ends, every register returns to its power-on value.

Top module: `wdog_ctrl`

## Requirements
- R1: A write to offset 0x00 updates the mode register only when data bits [31:24] equal 0x22. Otherwise the mode register is unchanged. The mode fields are: bit 0 enable, bit 1 external polarity (1 means active-high), bit 2 external output enable, bit 3 interrupt enable, bit 4 auto-start (stored only), and bit 6 two-stage mode.
- R2: A write to offset 0x04 updates the length only when data bits [4:0] equal 0x08. The length is taken from bits [15:5]. The power-on length is 1984 units.
- R3: While enabled, with no restart, the system reset rises exactly 512·L ticks after the counter was last loaded, where L is the length in units.
- R4: Writing the full word 0x00001971 to offset 0x08 reloads the counter with the length. Any other value written there has no effect.
- R5: A keyed length write, or a keyed mode write that turns enable from 0 to 1, reloads the counter so that counting restarts from the length.
- R6: With two-stage mode and the interrupt both enabled, the interrupt rises at 512·L ticks and the system reset rises at 2·512·L ticks. The interrupt stays high until a restart or a disable.
- R7: A keyed mode write that clears enable stops the countdown, so no reset follows. Bit 0 of a mode read shows the current enable state.
- R8: Writing 0x00001209 to offset 0x14 asserts the system reset on the next cycle, enabled or not. Other values written there are ignored.
- R9: The system reset stays high for exactly 16 ticks. When it drops, the mode register reads 0 and the length is back at 1984.
- R10: The external reset pin shows the system reset only when bit 2 is set. Its level when active follows bit 1. When idle, it sits at the inverse of bit 1.
- R11: Reads return the stored fields with key bits read as zero. Offset 0x00 returns the mode bits in place, offset 0x04 returns the length in bits [15:5], and all other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32 kHz tick enable |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Early-warning interrupt |
| sys_rst_o | output | 1 | System reset request, active high |
| ext_rst_o | output | 1 | External reset pin with programmable polarity |

## Verification
The assertions assume the following about the inputs:
- Each write strobe lasts one cycle.
- The tick input is a clean enable, sampled on the same clock.
- The bus does not write the length or restart registers in the same cycle in which an expiry lands.

The stimulus meets these conditions in the following ways:
- It drives every write for a single cycle, placed between clock edges.
- It holds the tick high throughout, so that each tick count equals a cycle count.
- It places restarts and length rewrites hundreds of cycles away from any unit boundary at which the counter is due to expire.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LEN   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SWRST = 8'h14;

  localparam logic [7:0]       MODE_KEY  = 8'h22;
  localparam logic [4:0]       LEN_KEY   = 5'h08;
  localparam logic [BUS_W-1:0] KICK_KEY  = 32'h0000_1971;
  localparam logic [BUS_W-1:0] SWRST_KEY = 32'h0000_1209;

  typedef struct packed {
    logic dual;
    logic autostart;
    logic irq_en;
    logic ext_en;
    logic pol_hi;
    logic en;
  } mode_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int LEN_RST = 1984
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              clr_i,
  output logic [BUS_W-1:0]  rdata_o,
  output mode_t             mode_o,
  output logic [CNT_W-1:0]  len_load_o,
  output logic              load_o,
  output logic              kick_o,
  output logic              swrst_o
);
  localparam int PAD_W = BUS_W - CNT_W - 5;

  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] len_q;
  logic             mode_wr, len_wr;

  assign mode_wr = we_i && addr_i == OFS_MODE && wdata_i[31:24] == MODE_KEY;
  assign len_wr  = we_i && addr_i == OFS_LEN  && wdata_i[4:0] == LEN_KEY;
  assign kick_o  = we_i && addr_i == OFS_KICK  && wdata_i == KICK_KEY;
  assign swrst_o = we_i && addr_i == OFS_SWRST && wdata_i == SWRST_KEY;

  assign mode_d = '{dual: wdata_i[6], autostart: wdata_i[4], irq_en: wdata_i[3],
                    ext_en: wdata_i[2], pol_hi: wdata_i[1], en: wdata_i[0]};

  assign len_load_o = len_wr ? wdata_i[5 +: CNT_W] : len_q;
  assign load_o     = len_wr || (mode_wr && mode_d.en && !mode_q.en);
  assign mode_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      len_q  <= CNT_W'(LEN_RST);
    end else if (clr_i) begin
      mode_q <= '0;
      len_q  <= CNT_W'(LEN_RST);
    end else begin
      if (mode_wr) mode_q <= mode_d;
      if (len_wr)  len_q  <= wdata_i[5 +: CNT_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_MODE: rdata_o = {25'b0, mode_q.dual, 1'b0, mode_q.autostart, mode_q.irq_en,
                           mode_q.ext_en, mode_q.pol_hi, mode_q.en};
      OFS_LEN:  rdata_o = {{PAD_W{1'b0}}, len_q, 5'b0};
      default:  rdata_o = '0;
    endcase
  end

  // R1
  a_r1_mode_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFS_MODE && wdata_i[31:24] != MODE_KEY && !clr_i |=> $stable(mode_q));
  // R9
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> mode_q == '0 && len_q == CNT_W'(LEN_RST));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W      = 11,
  parameter int UNIT_TICKS = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             dual_i,
  input  logic             irq_en_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] len_load_i,
  output logic             irq_o,
  output logic             expire_o
);
  localparam int PRE_W = $clog2(UNIT_TICKS);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stage_q, irq_q;
  logic             unit_end, last_unit, two_stage, run;

  assign unit_end  = tick_i && pre_q == PRE_W'(UNIT_TICKS - 1);
  assign last_unit = cnt_q <= CNT_W'(1);
  assign two_stage = dual_i && irq_en_i && !stage_q;
  assign run       = en_i && !hold_i && !load_i && !kick_i;
  assign expire_o  = run && unit_end && last_unit && !two_stage;
  assign irq_o     = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (load_i || kick_i) begin
      pre_q <= '0;
      cnt_q <= len_load_i;
      if (kick_i || !en_i) begin
        stage_q <= 1'b0;
        irq_q   <= 1'b0;
      end
    end else if (!en_i) begin
      pre_q   <= '0;
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!hold_i && tick_i) begin
      if (unit_end) begin
        pre_q <= '0;
        if (last_unit) begin
          cnt_q <= len_load_i;
          if (two_stage) begin
            stage_q <= 1'b1;
            irq_q   <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  // R4
  a_r4_kick_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_q == $past(len_load_i) && pre_q == '0 && !irq_o);
  // R6
  a_r6_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && en_i && !kick_i |=> irq_o);
  // R7
  a_r7_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o && pre_q == '0);
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
  parameter int RST_HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  output logic active_o,
  output logic done_o
);
  localparam int HW = $clog2(RST_HOLD + 1);

  logic [HW-1:0] cnt_q;

  assign active_o = cnt_q != '0;
  assign done_o   = tick_i && cnt_q == HW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (trig_i && !active_o) cnt_q <= HW'(RST_HOLD);
    else if (active_o && tick_i)  cnt_q <= cnt_q - HW'(1);
  end

  // R8
  a_r8_trig_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> active_o);
  // R9
  a_r9_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !tick_i |=> active_o);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int LEN_RST    = 1984,
  parameter int UNIT_TICKS = 512,
  parameter int RST_HOLD   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o,
  output logic        sys_rst_o,
  output logic        ext_rst_o
);
  mode_t            mode;
  logic [CNT_W-1:0] len_load;
  logic             load, kick, swrst, expire, active, done;

  wdog_regs #(.CNT_W(CNT_W), .LEN_RST(LEN_RST)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .clr_i(done), .rdata_o(bus_rdata_o), .mode_o(mode),
    .len_load_o(len_load), .load_o(load), .kick_o(kick), .swrst_o(swrst)
  );

  wdog_timer #(.CNT_W(CNT_W), .UNIT_TICKS(UNIT_TICKS)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .en_i(mode.en), .dual_i(mode.dual), .irq_en_i(mode.irq_en),
    .hold_i(active), .load_i(load), .kick_i(kick), .len_load_i(len_load),
    .irq_o(irq_o), .expire_o(expire)
  );

  wdog_rst_gen #(.RST_HOLD(RST_HOLD)) u_rst (
    .clk_i, .rst_ni, .tick_i,
    .trig_i(expire || swrst), .active_o(active), .done_o(done)
  );

  assign sys_rst_o = active;
  // idle level is the inverse of the selected polarity
  assign ext_rst_o = mode.pol_hi ? (active && mode.ext_en) : !(active && mode.ext_en);

  // R10
  a_r10_ext_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode.ext_en |-> ext_rst_o == !mode.pol_hi);
endmodule

// File: tb/tb_wdog_ctrl.sv
`timescale 1ns/1ps
module tb_wdog_ctrl;
  logic        clk = 0, rst_n = 0, tick = 1, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, rd_v;
  logic        irq, sys_rst, ext_rst;

  int total = 0, bad = 0, cyc = 0, last_c = 0;

  typedef struct {int kind; int at; string tag;} ev_t; // kind 0 rst rise, 1 irq rise, 2 rst fall
  ev_t q[$];

  wdog_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .sys_rst_o(sys_rst),
    .ext_rst_o(ext_rst)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1; we = 0; last_c = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_ev(input int k, input int t, input string tag);
    ev_t e; e.kind = k; e.at = t; e.tag = tag; q.push_back(e);
  endtask

  // monitor: compares observed edges with the queued expectations
  logic p_rst = 0, p_irq = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int k; k = -1;
      if (sys_rst && !p_rst) k = 0;
      else if (!sys_rst && p_rst) k = 2;
      if (k >= 0) begin
        if (q.size() == 0) chk(0, "R3 unexpected reset edge", k, -1);
        else begin
          ev_t e; e = q.pop_front();
          chk(e.kind == k && e.at == cyc, e.tag, cyc, e.at);
        end
      end
      if (irq && !p_irq) begin
        if (q.size() == 0) chk(0, "R6 unexpected irq", 1, -1);
        else begin
          ev_t e; e = q.pop_front();
          chk(e.kind == 1 && e.at == cyc, e.tag, cyc, e.at);
        end
      end
    end
    p_rst = sys_rst; p_irq = irq;
  end

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, ck;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(8'h00, rd_v); chk(rd_v == 0, "R11 mode reset read", rd_v, 0);
    rd(8'h04, rd_v); chk(rd_v == 32'hF800, "R2 length reset read", rd_v, 32'hF800);
    chk(!irq && !sys_rst && ext_rst, "R10 idle outputs", {irq, sys_rst, ext_rst}, 3'b001);
    rd(8'h08, rd_v); chk(rd_v == 0, "R11 other offset reads 0", rd_v, 0);

    // R1 wrong mode key
    wr(8'h00, 32'h2100_0001);
    rd(8'h00, rd_v); chk(rd_v == 0, "R1 bad key ignored", rd_v, 0);
    // R1/R11 field readback, key and unused bits read 0
    wr(8'h00, 32'h2200_00FE);
    rd(8'h00, rd_v); chk(rd_v == 32'h5E, "R11 mode readback", rd_v, 32'h5E);
    chk(ext_rst == 0, "R10 idle level with pol high", ext_rst, 0);
    wr(8'h00, 32'h2200_0000);

    // R2 length keys
    wr(8'h04, (32'd2 << 5) | 32'h08);
    rd(8'h04, rd_v); chk(rd_v == 32'h40, "R2 length write", rd_v, 32'h40);
    wr(8'h04, (32'd5 << 5) | 32'h09);
    rd(8'h04, rd_v); chk(rd_v == 32'h40, "R2 bad length key ignored", rd_v, 32'h40);

    // R3 plain timeout L=2, wrong restart ignored, R10 active high
    wr(8'h00, 32'h2200_0007); c0 = last_c;
    expect_ev(0, c0 + 1024, "R3 timeout rise");
    expect_ev(2, c0 + 1040, "R9 hold 16 ticks");
    wait_until(c0 + 500); wr(8'h08, 32'h0000_1972); // R4 wrong value
    wait_until(c0 + 1030);
    chk(sys_rst && ext_rst, "R10 ext active high", {sys_rst, ext_rst}, 2'b11);
    wait_until(c0 + 1045);
    rd(8'h00, rd_v); chk(rd_v == 0, "R9 mode cleared", rd_v, 0);
    rd(8'h04, rd_v); chk(rd_v == 32'hF800, "R9 length restored", rd_v, 32'hF800);

    // R4 restart postpones expiry
    wr(8'h04, (32'd2 << 5) | 32'h08);
    wr(8'h00, 32'h2200_0001); c0 = last_c;
    wait_until(c0 + 900); wr(8'h08, 32'h0000_1971); ck = last_c;
    expect_ev(0, ck + 1024, "R4 restart reload");
    expect_ev(2, ck + 1040, "R9 fall after restart");
    wait_until(ck + 1050);
    chk(q.size() == 0, "R4 events done", q.size(), 0);

    // R5 length rewrite mid-count
    wr(8'h04, (32'd2 << 5) | 32'h08);
    wr(8'h00, 32'h2200_0001); c0 = last_c;
    wait_until(c0 + 600); wr(8'h04, (32'd1 << 5) | 32'h08); ck = last_c;
    expect_ev(0, ck + 512, "R5 length reload");
    expect_ev(2, ck + 528, "R9 fall after reload");
    wait_until(ck + 540);

    // R6 two-stage
    wr(8'h04, (32'd1 << 5) | 32'h08);
    wr(8'h00, 32'h2200_0049); c0 = last_c;
    expect_ev(1, c0 + 512, "R6 irq at first expiry");
    expect_ev(0, c0 + 1024, "R6 reset at second expiry");
    expect_ev(2, c0 + 1040, "R9 fall after two-stage");
    wait_until(c0 + 1000);
    chk(irq == 1, "R6 irq held", irq, 1);
    wait_until(c0 + 1050);

    // R6 restart clears irq, R7 disable stops
    wr(8'h04, (32'd1 << 5) | 32'h08);
    wr(8'h00, 32'h2200_0049); c0 = last_c;
    expect_ev(1, c0 + 512, "R6 irq before restart");
    wait_until(c0 + 600); wr(8'h08, 32'h0000_1971);
    chk(irq == 0, "R6 restart clears irq", irq, 0);
    wait_until(c0 + 700); wr(8'h00, 32'h2200_0048);
    rd(8'h00, rd_v); chk(rd_v == 32'h48, "R7 enable reads 0", rd_v, 32'h48);
    wait_until(c0 + 2500);
    chk(!sys_rst && !irq && q.size() == 0, "R7 no reset after disable",
        {sys_rst, irq}, 0);

    // R8 software reset while disabled, R10 active low
    wr(8'h00, 32'h2200_0004);
    chk(ext_rst == 1, "R10 idle high with pol low", ext_rst, 1);
    wr(8'h14, 32'h0000_1208);
    wait_until(last_c + 10);
    chk(!sys_rst, "R8 wrong value ignored", sys_rst, 0);
    wr(8'h14, 32'h0000_1209); ck = last_c;
    expect_ev(0, ck, "R8 immediate reset");
    expect_ev(2, ck + 16, "R9 sw reset hold");
    wait_until(ck + 5);
    chk(ext_rst == 0, "R10 ext active low", ext_rst, 0);
    wait_until(ck + 20);
    rd(8'h00, rd_v); chk(rd_v == 0, "R9 mode cleared after sw reset", rd_v, 0);
    chk(q.size() == 0, "R8 all events seen", q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule